// File: doc/BRIEF.md
# Divided Clock Output Gate

This block produces the final clock output of a clock synthesizer. It takes the loop (PLL) clock or the crystal reference clock, divides the chosen source by a power of two, and gates the result with an external control pin. The source is picked by a select bit, and a 3-bit code picks the ratio. With the control pin low the output is released. The release is modelled as a drive-enable flag plus data held at zero, which stands for a weak pull-down on a tri-stated pad.

Two configuration bits shape the gating. A mode bit picks between output-enable behaviour and power-down behaviour. In power-down mode the block also raises a shutdown request for the oscillator and the loop. After wake-up it keeps the output off until an external lock indication returns. A timing bit picks how the output is switched off. In asynchronous timing the output is cut at once. In synchronous timing the output is cut only after the divided clock has completed a falling edge. Switching back on always happens while the divided clock is low, with the divider restarted from zero, so the first high phase has full width.

The source select and the divide code are static settings, changed only while reset is held. The lock indication is synchronous to the selected source clock.

Top module: `clkout_gate`

## Requirements
- R1: While `rst_n` is low, `oe_o`, `clk_o` and `shut_o` are all 0.
- R2: `src_sel_i` = 0 divides `pll_clk`; `src_sel_i` = 1 divides `ref_clk`.
- R3: With divide code k on `div_sel_i`, the output period is 2^k source periods. For k ≥ 1 the high phase lasts 2^(k-1) source periods. For k = 0 the output follows the source clock.
- R4: Whenever `oe_o` is 0, `clk_o` is 0.
- R5: With `async_i` = 1, `oe_o` drops in the same instant that `ctl_pin_i` goes low, even during a high phase. It stays low afterwards.
- R6: With `async_i` = 0, `ctl_pin_i` is resynchronized by two source falling-edge flops. The output is switched off at the source falling edge that follows a falling edge of the divided clock. The last high pulse has full width, and the shut-off latency is at most one output period plus three source periods.
- R7: Switching on happens at a source falling edge while the output is low, in both timing modes. The divider restarts from zero, so the first high phase has full width. It begins 2^(k-1) - 1/2 source periods after `oe_o` rises, or half a source period when k = 0.
- R8: With `pd_mode_i` = 1, `shut_o` is the inverse of the resynchronized pin, registered on a source falling edge. With `pd_mode_i` = 0, `shut_o` stays 0.
- R9: With `pd_mode_i` = 1, the output is not switched back on while `lock_i` is 0. It is switched on at the first source falling edge with `lock_i` = 1 and the resynchronized pin high.
- R10: With `pd_mode_i` = 0, `lock_i` has no effect, and the output is switched on with `lock_i` held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | Loop output clock |
| ref_clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Source choice: 0 loop clock, 1 reference clock |
| div_sel_i | input | 3 | Divide code k, ratio 2^k |
| ctl_pin_i | input | 1 | Control pin, high allows output |
| pd_mode_i | input | 1 | 1 power-down behaviour, 0 output-enable behaviour |
| async_i | input | 1 | 1 immediate shut-off, 0 edge-aligned shut-off |
| lock_i | input | 1 | Loop and oscillator ready after wake-up |
| clk_o | output | 1 | Output clock data, 0 while not driven |
| oe_o | output | 1 | Output drive enable |
| shut_o | output | 1 | Shutdown request to the oscillator and loop |

## Verification
Most faults in the divider counter or its tap selection show up at the output pin within one or two output periods. They appear as a wrong period, a wrong high width, or a first pulse that is shortened after switch-on. A fault in the gating state machine shows up on the first shut-off or switch-on that follows: a high pulse that is cut short in synchronous timing, a drive enable that survives a low pin, or an output that returns before lock. A fault in the shutdown register appears at `shut_o` within three source periods of a pin change.

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate #(
  parameter int SEL_W = 3
) (
  input  logic             pll_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             src_sel_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             ctl_pin_i,
  input  logic             pd_mode_i,
  input  logic             async_i,
  input  logic             lock_i,
  output logic             clk_o,
  output logic             oe_o,
  output logic             shut_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic             src_clk;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   taps;
  logic             dclk;
  logic             last_bit;
  logic [1:0]       pin_sync;
  logic             pin_s;
  logic             fall_now;
  logic             go;
  logic             en_q;
  logic             shut_q;
  logic             drive;

  assign src_clk  = src_sel_i ? ref_clk : pll_clk;
  assign taps     = {cnt, src_clk};
  assign dclk     = taps[div_sel_i];
  assign pin_s    = pin_sync[1];
  assign fall_now = (div_sel_i == '0) | (last_bit & ~dclk);
  assign go       = pin_s & (~pd_mode_i | lock_i);

  // divider runs only while the output is on, so it restarts from zero
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      last_bit <= 1'b0;
    end else begin
      cnt      <= en_q ? cnt + 1'b1 : '0;
      last_bit <= dclk;
    end
  end

  // gating state changes only on source falling edges
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= 2'b00;
      en_q     <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], ctl_pin_i};
      shut_q   <= pd_mode_i & ~pin_s;
      if (!en_q)
        en_q <= go;
      else if ((async_i && !pin_s) || (fall_now && !go))
        en_q <= 1'b0;
    end
  end

  assign drive  = en_q & ~(async_i & ~ctl_pin_i);
  assign oe_o   = drive;
  assign clk_o  = drive & dclk;
  assign shut_o = shut_q;

endmodule

// File: rtl/clkout_gate_chk.sv
`timescale 1ns/1ps
module clkout_gate_chk #(
  parameter int CNT_W = 7
) (
  input logic             src_clk,
  input logic             rst_n,
  input logic             async_i,
  input logic             pd_mode_i,
  input logic             lock_i,
  input logic             ctl_pin_i,
  input logic             clk_o,
  input logic             oe_o,
  input logic             shut_o,
  input logic             en_q,
  input logic             pin_s,
  input logic             fall_now,
  input logic [CNT_W-1:0] cnt
);
  AST_LOW_WHEN_RELEASED: assert property (@(negedge src_clk) disable iff (!rst_n)
    !oe_o |-> !clk_o); // R4

  AST_ASYNC_CUT: assert property (@(negedge src_clk) disable iff (!rst_n)
    (async_i && !ctl_pin_i) |-> !oe_o); // R5

  AST_SYNC_HOLD: assert property (@(negedge src_clk) disable iff (!rst_n)
    (!async_i && en_q && !fall_now) |=> en_q); // R6

  AST_FRESH_START: assert property (@(negedge src_clk) disable iff (!rst_n)
    $rose(en_q) |-> (cnt == 1)); // R7

  AST_SHUT_TRACKS: assert property (@(negedge src_clk) disable iff (!rst_n)
    rst_n |=> (shut_o == $past(pd_mode_i && !pin_s))); // R8

  AST_WAIT_LOCK: assert property (@(negedge src_clk) disable iff (!rst_n)
    (pd_mode_i && !en_q) |=> (!en_q || $past(lock_i))); // R9
endmodule

bind clkout_gate clkout_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .src_clk  (src_clk),
  .rst_n    (rst_n),
  .async_i  (async_i),
  .pd_mode_i(pd_mode_i),
  .lock_i   (lock_i),
  .ctl_pin_i(ctl_pin_i),
  .clk_o    (clk_o),
  .oe_o     (oe_o),
  .shut_o   (shut_o),
  .en_q     (en_q),
  .pin_s    (pin_s),
  .fall_now (fall_now),
  .cnt      (cnt)
);

// File: tb/tb_clkout_gate.sv
`timescale 1ns/1ps
module tb_clkout_gate;
  localparam real CLK_PERIOD = 10.0;
  localparam real REF_PERIOD = 14.0;
  localparam int  WDOG_LIMIT = 150000;

  logic pll_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic ctl_pin = 1'b0;
  logic pd_mode = 1'b0;
  logic async_m = 1'b0;
  logic lock = 1'b0;
  logic clk_o, oe_o, shut_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  real last_rise = 0.0;
  real last_hi = 0.0;

  clkout_gate dut (
    .pll_clk(pll_clk), .ref_clk(ref_clk), .rst_n(rst_n), .src_sel_i(src_sel),
    .div_sel_i(div_sel), .ctl_pin_i(ctl_pin), .pd_mode_i(pd_mode),
    .async_i(async_m), .lock_i(lock), .clk_o(clk_o), .oe_o(oe_o), .shut_o(shut_o)
  );

  always #(CLK_PERIOD/2) pll_clk = ~pll_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  always @(posedge clk_o) last_rise = $realtime;
  always @(negedge clk_o) last_hi = $realtime - last_rise;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge pll_clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, WDOG_LIMIT);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
    end
  endtask

  task automatic chk_t(input string req, input real act, input real exp);
    chk((act - exp < 0.01) && (exp - act < 0.01), req, act, exp);
  endtask

  task automatic run_cfg(input int s, input int c, input bit a);
    real t, hi, per, first, tr, tf, t1, tp;
    t     = (s != 0) ? REF_PERIOD : CLK_PERIOD;
    per   = t * (2.0 ** c);
    hi    = (c == 0) ? t / 2.0 : t * (2.0 ** (c - 1));
    first = (c == 0) ? t / 2.0 : hi - t / 2.0;

    rst_n = 1'b0; ctl_pin = 1'b0; pd_mode = 1'b0; lock = 1'b0;
    src_sel = s[0]; div_sel = c[2:0]; async_m = a;
    #(3.0 * REF_PERIOD + 1.3);
    chk(!oe_o && !clk_o && !shut_o, "R1 reset outputs", real'({oe_o, clk_o, shut_o}), 0.0);
    rst_n = 1'b1;
    #7.3 ctl_pin = 1'b1;

    // R10: lock held at 0 in output-enable mode, output still comes on
    @(posedge oe_o); tr = $realtime;
    #0.1 chk(!clk_o, "R7 low at switch-on", real'(clk_o), 0.0);
    @(posedge clk_o); t1 = $realtime;
    chk_t("R7 first rise delay", t1 - tr, first);
    @(negedge clk_o); tf = $realtime;
    chk_t("R7 first high full width", tf - t1, hi);
    @(posedge clk_o);
    chk_t(s != 0 ? "R2 R3 period on reference source" : "R2 R3 period on loop source", $realtime - t1, per);
    t1 = $realtime;
    @(negedge clk_o);
    chk_t("R3 steady high width", $realtime - t1, hi);

    if (!a) begin
      #3.1 ctl_pin = 1'b0; tp = $realtime;
      @(negedge oe_o);
      #0.1;
      chk(!clk_o, "R6 output low at shut-off", real'(clk_o), 0.0);
      chk_t("R6 last high pulse full", last_hi, hi);
      chk(($realtime - tp) <= per + 3.0 * t + 0.2, "R6 shut-off latency", $realtime - tp, per + 3.0 * t);
    end else begin
      @(posedge clk_o);
      #1.0 ctl_pin = 1'b0;
      #0.5;
      chk(!oe_o, "R5 immediate cut", real'(oe_o), 0.0);
      chk(!clk_o, "R4 data low when cut", real'(clk_o), 0.0);
    end

    #(per + 5.0 * t);
    chk(!oe_o && !clk_o, "R4 stays released", real'({oe_o, clk_o}), 0.0);
    chk(!shut_o, "R8 no shutdown in output-enable mode", real'(shut_o), 0.0);

    #2.3 ctl_pin = 1'b1;
    @(posedge oe_o); tr = $realtime;
    @(posedge clk_o); t1 = $realtime;
    chk_t("R7 restart rise delay", t1 - tr, first);
    @(negedge clk_o);
    chk_t("R7 restart high full width", $realtime - t1, hi);
  endtask

  task automatic run_pd();
    real t1;
    rst_n = 1'b0; ctl_pin = 1'b0; pd_mode = 1'b1; lock = 1'b1;
    src_sel = 1'b0; div_sel = 3'd2; async_m = 1'b0;
    #31.3 rst_n = 1'b1;
    #6.2 ctl_pin = 1'b1;
    @(posedge oe_o);
    #40.2 chk(!shut_o, "R8 no request while pin high", real'(shut_o), 0.0);
    ctl_pin = 1'b0;
    #(4.0 * CLK_PERIOD);
    chk(shut_o, "R8 request after pin low", real'(shut_o), 1.0);
    #(5.0 * CLK_PERIOD);
    chk(!oe_o, "R4 released in power-down", real'(oe_o), 0.0);
    lock = 1'b0;
    ctl_pin = 1'b1;
    #(4.0 * CLK_PERIOD);
    chk(!shut_o, "R8 request withdrawn", real'(shut_o), 0.0);
    #(20.0 * CLK_PERIOD);
    chk(!oe_o, "R9 held off until lock", real'(oe_o), 0.0);
    lock = 1'b1;
    t1 = $realtime;
    @(posedge oe_o);
    chk(($realtime - t1) <= CLK_PERIOD, "R9 on after lock", $realtime - t1, CLK_PERIOD);
    @(posedge clk_o); t1 = $realtime;
    @(negedge clk_o);
    chk_t("R7 first high after wake", $realtime - t1, 2.0 * CLK_PERIOD);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++)
        run_cfg(s, c, ((s + c) % 2) == 1);
    run_pd();
    summary();
  end
endmodule